// File: doc/BRIEF.md
# SPI Master Transaction Engine

A register-mapped SPI master that runs one complete transaction each time software writes its start register. Software selects a unit length, a clock divider and a transfer-control word holding a 4-bit mode code plus separate write and read unit counts (each stored as count minus one). The engine then drives chip select, SCK and MOSI. It takes outgoing units from a transmit FIFO and places sampled MISO units in a receive FIFO.

A single start can run a command write followed by a read under one chip-select window, with no software action between the two phases. When the transmit FIFO runs dry, or the receive FIFO fills, the engine pauses with SCK low and chip select held. Nothing is lost and nothing is sent twice. Clocking is SPI mode 0: SCK idles low, MOSI is valid before each rising edge and MISO is sampled on it.

Top module: `spi_txn_master`

## Requirements
- R1: After reset cs_n_o is 1, sck_o is 0, the status word reads 0x0040_4000 (both FIFOs empty, idle), the format word reads 0x0000_0700 and the control word reads 0.
- R2: Word addresses: 0 format, 1 transfer control, 2 start, 3 data, 4 control, 5 status, 6 divider. In transfer control, bits 27:24 are the mode, 20:12 the write count minus one, and 8:0 the read count minus one. Any write to address 2 while idle starts a transaction. In status, bit 0 is busy, 12:8 the receive level, 14 receive empty, 20:16 the transmit level, 22 transmit empty and 23 transmit full.
- R3: Mode 1 (write only) shifts write-count units out on MOSI, MSB first, and stores nothing in the receive FIFO.
- R4: Mode 2 (read only) samples read-count units on rising SCK edges into the receive FIFO, holding MOSI at 0.
- R5: Mode 3 runs the write units and then the read units under one chip-select window. MISO is ignored while writing and MOSI is 0 while reading.
- R6: Mode 0 moves write-count units, each sent on MOSI and captured from MISO at the same time.
- R7: Mode 7 and every code other than 0 to 3 start nothing: chip select stays high and busy stays 0.
- R8: Format bits 10:8 hold unit length minus one (1 to 8 bits). A unit sends and returns its low L bits, MSB first.
- R9: With divider value d in bits 7:0, every SCK high phase lasts d+1 clocks and every low phase lasts at least d+1 clocks. Chip select falls at least d+1 clocks before the first rising edge. It rises exactly d+1 clocks after the last falling edge, in the same cycle that busy clears.
- R10: If the transmit FIFO is empty when a sending unit is due, SCK holds low with chip select asserted until data is written.
- R11: If the receive FIFO is full when a receiving unit is due, SCK holds low with chip select asserted until a unit is read.
- R12: Each FIFO holds 16 units. A data write to a full transmit FIFO is dropped. A data read pops the receive FIFO.
- R13: Control bit 2 flushes the transmit FIFO, bit 1 flushes the receive FIFO and bit 0 aborts the engine (chip select released, busy cleared). Each of these bits reads 0 again one cycle after it acts. Bits 4:3 read back as written and change no behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench goes after the phase boundary in mode 3. An engine that samples MISO during the write phase would return units shifted by the write length. One that drops chip select between the phases would show a second falling edge on cs_n_o. For both stalls, it checks that SCK and chip select freeze at exact edge counts (8 and 128) and resume later. A design that underflowed or overflowed a FIFO would emit extra edges or lose a unit. Short units (1, 3 and 5 bits), divider timing, an abort in mid-read, a dropped seventeenth push and inert mode codes close the list. Each is a place where a wrong design would show a wrong edge count, a wrong half-period or a stray busy.

// File: rtl/spi_txn_pkg.sv
package spi_txn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_FETCH, ST_LO, ST_HI, ST_TRAIL
  } eng_state_e;

  typedef enum logic [1:0] {PH_WR, PH_RD, PH_BOTH} phase_e;

  localparam logic [3:0] MODE_BOTH  = 4'd0;
  localparam logic [3:0] MODE_WR    = 4'd1;
  localparam logic [3:0] MODE_RD    = 4'd2;
  localparam logic [3:0] MODE_WR_RD = 4'd3;

  localparam logic [2:0] REG_FMT  = 3'd0;
  localparam logic [2:0] REG_XCTL = 3'd1;
  localparam logic [2:0] REG_CMD  = 3'd2;
  localparam logic [2:0] REG_DATA = 3'd3;
  localparam logic [2:0] REG_CTRL = 3'd4;
  localparam logic [2:0] REG_STAT = 3'd5;
  localparam logic [2:0] REG_TIME = 3'd6;

  localparam int MODE_LSB = 24;
  localparam int WCNT_LSB = 12;
  localparam int RCNT_LSB = 0;
  localparam int LEN_LSB  = 8;
  localparam int RXC_LSB  = 8;
  localparam int TXC_LSB  = 16;
endpackage

// File: rtl/spi_txn_fifo.sv
module spi_txn_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    count_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_txn_engine.sv
module spi_txn_engine
  import spi_txn_pkg::*;
#(
  parameter int UNIT_W = 8,
  parameter int CNT_W  = 9,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(UNIT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              start_i,
  input  logic [3:0]        mode_i,
  input  logic [CNT_W-1:0]  wcnt_i,
  input  logic [CNT_W-1:0]  rcnt_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              tx_empty_i,
  input  logic [UNIT_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  input  logic              rx_full_i,
  output logic              rx_push_o,
  output logic [UNIT_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  eng_state_e        state_q;
  phase_e            phase_q, st_phase;
  logic              then_rd_q, st_then, start_ok;
  logic [CNT_W-1:0]  rcnt_q, units_q, st_units;
  logic [LEN_W-1:0]  len_q, bit_q;
  logic [DIV_W-1:0]  div_q, timer_q;
  logic [UNIT_W-1:0] tx_sh_q, rx_sh_q, len_mask;
  logic              ph_tx, ph_rx, can_go, half_done, unit_end;

  always_comb begin
    start_ok = 1'b1;
    st_phase = PH_BOTH;
    st_units = wcnt_i;
    st_then  = 1'b0;
    case (mode_i)
      MODE_BOTH:  ;
      MODE_WR:    st_phase = PH_WR;
      MODE_RD:    begin st_phase = PH_RD; st_units = rcnt_i; end
      MODE_WR_RD: begin st_phase = PH_WR; st_then = 1'b1; end
      default:    start_ok = 1'b0;
    endcase
  end

  assign ph_tx     = (phase_q != PH_RD);
  assign ph_rx     = (phase_q != PH_WR);
  assign can_go    = (!ph_tx || !tx_empty_i) && (!ph_rx || !rx_full_i);
  assign half_done = (timer_q == div_q);
  assign unit_end  = (state_q == ST_HI) && half_done && (bit_q == '0);

  always_comb begin
    for (int i = 0; i < UNIT_W; i++) len_mask[i] = (i <= int'(len_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_BOTH;
      then_rd_q <= 1'b0;
      rcnt_q    <= '0;
      units_q   <= '0;
      len_q     <= '0;
      bit_q     <= '0;
      div_q     <= '0;
      timer_q   <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
    end else if (soft_rst_i) begin
      state_q   <= ST_IDLE;
      then_rd_q <= 1'b0;
      timer_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i && start_ok) begin
          state_q   <= ST_LEAD;
          phase_q   <= st_phase;
          units_q   <= st_units;
          then_rd_q <= st_then;
          rcnt_q    <= rcnt_i;
          len_q     <= len_m1_i;
          div_q     <= div_i;
          timer_q   <= '0;
        end
        ST_LEAD: begin
          timer_q <= half_done ? '0 : timer_q + 1'b1;
          if (half_done) state_q <= ST_FETCH;
        end
        ST_FETCH: if (can_go) begin
          tx_sh_q <= ph_tx ? tx_data_i : '0;
          bit_q   <= len_q;
          timer_q <= '0;
          state_q <= ST_LO;
        end
        ST_LO: begin
          timer_q <= half_done ? '0 : timer_q + 1'b1;
          if (half_done) begin
            rx_sh_q <= {rx_sh_q[UNIT_W-2:0], miso_i};
            state_q <= ST_HI;
          end
        end
        ST_HI: begin
          timer_q <= half_done ? '0 : timer_q + 1'b1;
          if (half_done) begin
            if (bit_q != '0) begin
              bit_q   <= bit_q - 1'b1;
              state_q <= ST_LO;
            end else if (units_q != '0) begin
              units_q <= units_q - 1'b1;
              state_q <= ST_FETCH;
            end else if (then_rd_q) begin
              then_rd_q <= 1'b0;
              phase_q   <= PH_RD;
              units_q   <= rcnt_q;
              state_q   <= ST_FETCH;
            end else begin
              state_q <= ST_TRAIL;
            end
          end
        end
        ST_TRAIL: begin
          timer_q <= half_done ? '0 : timer_q + 1'b1;
          if (half_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_pop_o  = (state_q == ST_FETCH) && can_go && ph_tx && !soft_rst_i;
  assign rx_push_o = unit_end && ph_rx && !soft_rst_i;
  assign rx_data_o = rx_sh_q & len_mask;
  assign busy_o    = (state_q != ST_IDLE);
  assign cs_n_o    = (state_q == ST_IDLE);
  assign sck_o     = (state_q == ST_HI);
  assign mosi_o    = ((state_q == ST_LO) || (state_q == ST_HI)) && ph_tx && tx_sh_q[bit_q];
endmodule

// File: rtl/spi_txn_master.sv
module spi_txn_master
  import spi_txn_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int UNIT_W     = 8,
  parameter int CNT_W      = 9,
  parameter int DIV_W      = 8,
  parameter int ADDR_W     = 3,
  parameter int BUS_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              sck_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int LEN_W = $clog2(UNIT_W);
  localparam int CW    = $clog2(FIFO_DEPTH + 1);

  logic [LEN_W-1:0]  fmt_len_q;
  logic [3:0]        mode_q;
  logic [CNT_W-1:0]  wcnt_q, rcnt_q;
  logic [4:0]        ctrl_q;
  logic [DIV_W-1:0]  div_q;

  logic wr, rd, cmd_wr, ctrl_wr, tx_push, rx_pop;
  logic tx_pop, tx_empty, tx_full, rx_push, rx_empty, rx_full, eng_busy;
  logic [UNIT_W-1:0] tx_head, rx_head, rx_word;
  logic [CW-1:0]     tx_cnt, rx_cnt;

  assign wr      = bus_req_i && bus_we_i;
  assign rd      = bus_req_i && !bus_we_i;
  assign cmd_wr  = wr && (bus_addr_i == REG_CMD);
  assign ctrl_wr = wr && (bus_addr_i == REG_CTRL);
  assign tx_push = wr && (bus_addr_i == REG_DATA);
  assign rx_pop  = rd && (bus_addr_i == REG_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_len_q <= LEN_W'(UNIT_W - 1);
      mode_q    <= '0;
      wcnt_q    <= '0;
      rcnt_q    <= '0;
      ctrl_q    <= '0;
      div_q     <= '0;
    end else begin
      if (wr && bus_addr_i == REG_FMT)  fmt_len_q <= bus_wdata_i[LEN_LSB +: LEN_W];
      if (wr && bus_addr_i == REG_TIME) div_q <= bus_wdata_i[DIV_W-1:0];
      if (wr && bus_addr_i == REG_XCTL) begin
        mode_q <= bus_wdata_i[MODE_LSB +: 4];
        wcnt_q <= bus_wdata_i[WCNT_LSB +: CNT_W];
        rcnt_q <= bus_wdata_i[RCNT_LSB +: CNT_W];
      end
      // reset bits act for one cycle, then drop
      if (ctrl_wr) ctrl_q <= bus_wdata_i[4:0];
      else         ctrl_q[2:0] <= '0;
    end
  end

  spi_txn_fifo #(.WIDTH(UNIT_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i (ctrl_q[2]),
    .push_i  (tx_push),
    .wdata_i (bus_wdata_i[UNIT_W-1:0]),
    .pop_i   (tx_pop),
    .rdata_o (tx_head),
    .count_o (tx_cnt),
    .empty_o (tx_empty),
    .full_o  (tx_full)
  );

  spi_txn_fifo #(.WIDTH(UNIT_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i (ctrl_q[1]),
    .push_i  (rx_push),
    .wdata_i (rx_word),
    .pop_i   (rx_pop),
    .rdata_o (rx_head),
    .count_o (rx_cnt),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  spi_txn_engine #(.UNIT_W(UNIT_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_engine (
    .clk_i, .rst_ni,
    .soft_rst_i (ctrl_q[0]),
    .start_i    (cmd_wr),
    .mode_i     (mode_q),
    .wcnt_i     (wcnt_q),
    .rcnt_i     (rcnt_q),
    .len_m1_i   (fmt_len_q),
    .div_i      (div_q),
    .tx_empty_i (tx_empty),
    .tx_data_i  (tx_head),
    .tx_pop_o   (tx_pop),
    .rx_full_i  (rx_full),
    .rx_push_o  (rx_push),
    .rx_data_o  (rx_word),
    .busy_o     (eng_busy),
    .sck_o, .cs_n_o, .mosi_o, .miso_i
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      REG_FMT:  bus_rdata_o[LEN_LSB +: LEN_W] = fmt_len_q;
      REG_XCTL: begin
        bus_rdata_o[MODE_LSB +: 4]     = mode_q;
        bus_rdata_o[WCNT_LSB +: CNT_W] = wcnt_q;
        bus_rdata_o[RCNT_LSB +: CNT_W] = rcnt_q;
      end
      REG_DATA: bus_rdata_o[UNIT_W-1:0] = rx_head;
      REG_CTRL: bus_rdata_o[4:0] = ctrl_q;
      REG_STAT: begin
        bus_rdata_o[0]                = eng_busy;
        bus_rdata_o[RXC_LSB +: CW]    = rx_cnt;
        bus_rdata_o[14]               = rx_empty;
        bus_rdata_o[TXC_LSB +: CW]    = tx_cnt;
        bus_rdata_o[22]               = tx_empty;
        bus_rdata_o[23]               = tx_full;
      end
      REG_TIME: bus_rdata_o[DIV_W-1:0] = div_q;
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_txn_master_chk.sv
module spi_txn_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sck_i,
  input logic       cs_n_i,
  input logic       start_i,
  input logic       tx_pop_i,
  input logic       tx_empty_i,
  input logic       tx_full_i,
  input logic       rx_push_i,
  input logic       rx_full_i,
  input logic       ctrl_wr_i,
  input logic [2:0] rst_bits_i
);
  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> !sck_i); // R9

  AST_CS_FALL_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_i) |-> $past(start_i)); // R2

  AST_NO_TX_UNDERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_i |-> !tx_empty_i); // R10

  AST_NO_RX_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i |-> !rx_full_i); // R11

  AST_TX_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_empty_i && tx_full_i)); // R12

  AST_RST_BITS_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rst_bits_i != 3'b000) && !ctrl_wr_i) |=> (rst_bits_i == 3'b000)); // R13
endmodule

bind spi_txn_master spi_txn_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sck_i      (sck_o),
  .cs_n_i     (cs_n_o),
  .start_i    (cmd_wr),
  .tx_pop_i   (tx_pop),
  .tx_empty_i (tx_empty),
  .tx_full_i  (tx_full),
  .rx_push_i  (rx_push),
  .rx_full_i  (rx_full),
  .ctrl_wr_i  (ctrl_wr),
  .rst_bits_i (ctrl_q[2:0])
);

// File: tb/spi_txn_master_tb.sv
`timescale 1ns/1ps
module spi_txn_master_tb;
  localparam int PER = 8;
  localparam logic [2:0] A_FMT = 0, A_XCTL = 1, A_CMD = 2, A_DATA = 3,
                         A_CTRL = 4, A_STAT = 5, A_TIME = 6;
  // {mode[31:28], n_wr[27:20], n_rd[19:12], len_m1[11:8], div[7:0]}
  localparam logic [31:0] VEC [7] = '{
    {4'd1, 8'd2, 8'd0, 4'd7, 8'd1},
    {4'd2, 8'd0, 8'd3, 4'd7, 8'd0},
    {4'd3, 8'd1, 8'd2, 4'd7, 8'd2},
    {4'd0, 8'd3, 8'd0, 4'd7, 8'd1},
    {4'd1, 8'd3, 8'd0, 4'd4, 8'd0},
    {4'd3, 8'd2, 8'd2, 4'd2, 8'd0},
    {4'd0, 8'd2, 8'd0, 4'd0, 8'd3}
  };

  logic clk = 0, rst_ni = 0;
  logic bus_req = 0, bus_we = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sck, cs_n, mosi, miso;

  int checks = 0, fails = 0;
  int edge_cnt = 0, ptr = 0, hi_bad = 0, cur_div = 0;
  logic mosi_bits [0:511];
  time t_rise = 0, t_first = 0, t_last_fall = 0, t_cs_fall = 0, t_cs_rise = 0;

  always #(PER/2) clk = ~clk;

  spi_txn_master u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .sck_o(sck), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  function automatic logic pat(int p);
    return (((p * 13) + (p >> 2)) % 7) < 3;
  endfunction

  assign miso = pat(ptr);

  always @(negedge cs_n) begin ptr = 0; t_cs_fall = $time; end
  always @(posedge cs_n) t_cs_rise = $time;
  always @(posedge sck) begin
    if (edge_cnt == 0) t_first = $time;
    if (edge_cnt < 512) mosi_bits[edge_cnt] = mosi;
    edge_cnt++;
    t_rise = $time;
  end
  always @(negedge sck) begin
    if (($time - t_rise) != time'((cur_div + 1) * PER)) hi_bad++;
    t_last_fall = $time;
    ptr++;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (cs_n === 1'b0) @(negedge clk);
  endtask

  function automatic int exp_unit(int off, int len);
    int v = 0;
    for (int i = 0; i < len; i++) v = (v << 1) | int'(pat(off + i));
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  txv [16];
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    check(cs_n === 1'b1 && sck === 1'b0, "R1 pins", {cs_n, sck}, 2'b10);
    bus_rd(A_STAT, r); check(r == 32'h0040_4000, "R1 status", r, 32'h0040_4000);
    bus_rd(A_FMT, r);  check(r == 32'h0000_0700, "R1 format", r, 32'h700);
    bus_rd(A_CTRL, r); check(r == 0, "R1 control", r, 0);

    // R13 storage bits 4:3 are inert
    bus_wr(A_CTRL, 32'h18);
    bus_rd(A_CTRL, r); check(r == 32'h18, "R13 dma bits kept", r, 32'h18);

    foreach (VEC[vi]) begin
      int mode, nw, nr, len, dv, units, off, bad, nrx;
      mode = int'(VEC[vi][31:28]); nw = int'(VEC[vi][27:20]);
      nr = int'(VEC[vi][19:12]); len = int'(VEC[vi][11:8]) + 1; dv = int'(VEC[vi][7:0]);
      cur_div = dv;
      bus_wr(A_FMT, 32'(len - 1) << 8);
      bus_wr(A_TIME, 32'(dv));
      if (mode != 2)
        for (int k = 0; k < nw; k++) begin
          txv[k] = 8'h5A ^ 8'(k * 29) ^ 8'(vi * 83);
          bus_wr(A_DATA, {24'd0, txv[k]});
        end
      bus_wr(A_XCTL, (32'(mode) << 24) | (32'(nw > 0 ? nw - 1 : 0) << 12) | 32'(nr > 0 ? nr - 1 : 0));
      edge_cnt = 0; hi_bad = 0;
      bus_wr(A_CMD, 32'd1);
      wait_done();
      units = (mode == 2) ? nr : (mode == 3) ? nw + nr : nw;
      check(edge_cnt == units * len, "R3 R4 R5 R6 R8 edge count", edge_cnt, units * len);
      bad = 0;
      for (int u = 0; u < units; u++)
        for (int b = 0; b < len; b++) begin
          logic e;
          e = (mode == 2 || (mode == 3 && u >= nw)) ? 1'b0 : txv[u][len - 1 - b];
          if (mosi_bits[u * len + b] !== e) bad++;
        end
      check(bad == 0, "R3 R5 R8 mosi bits", bad, 0);
      check(hi_bad == 0, "R9 sck high time", hi_bad, 0);
      check((t_cs_rise - t_last_fall) == time'((dv + 1) * PER), "R9 cs trail",
            int'((t_cs_rise - t_last_fall) / PER), dv + 1);
      check((t_first - t_cs_fall) >= time'((dv + 1) * PER), "R9 cs lead",
            int'((t_first - t_cs_fall) / PER), dv + 1);
      bus_rd(A_STAT, r);
      check(r[0] == 1'b0, "R9 busy clear with cs", int'(r[0]), 0);
      nrx = (mode == 1) ? 0 : (mode == 0) ? nw : nr;
      off = (mode == 3) ? nw * len : 0;
      check(int'(r[12:8]) == nrx, "R3 R4 rx level", int'(r[12:8]), nrx);
      for (int u = 0; u < nrx; u++) begin
        int e;
        e = exp_unit(off + u * len, len);
        bus_rd(A_DATA, r);
        check(int'(r) == e, "R4 R5 R6 rx unit", int'(r), e);
      end
    end

    // R7 inert mode codes
    cur_div = 0;
    bus_wr(A_FMT, 32'h700); bus_wr(A_TIME, 0);
    for (int c = 7; c <= 12; c += 5) begin
      edge_cnt = 0;
      bus_wr(A_XCTL, 32'(c) << 24);
      bus_wr(A_CMD, 1);
      repeat (10) @(negedge clk);
      bus_rd(A_STAT, r);
      check(cs_n === 1'b1 && r[0] == 1'b0 && edge_cnt == 0, "R7 no-data code", {r[0], cs_n}, 1);
    end

    // R10 tx stall
    bus_wr(A_DATA, 32'h81);
    bus_wr(A_XCTL, (32'd1 << 24) | (32'd1 << 12));
    edge_cnt = 0; hi_bad = 0;
    bus_wr(A_CMD, 1);
    repeat (200) @(negedge clk);
    check(edge_cnt == 8 && cs_n === 1'b0 && sck === 1'b0, "R10 stall on empty", edge_cnt, 8);
    bus_wr(A_DATA, 32'h3C);
    wait_done();
    check(edge_cnt == 16, "R10 resume", edge_cnt, 16);

    // R11 rx stall with 17 units
    bus_wr(A_XCTL, (32'd2 << 24) | 32'd16);
    edge_cnt = 0;
    bus_wr(A_CMD, 1);
    repeat (400) @(negedge clk);
    bus_rd(A_STAT, r);
    check(edge_cnt == 128 && cs_n === 1'b0 && int'(r[12:8]) == 16, "R11 stall on full", edge_cnt, 128);
    bus_rd(A_DATA, r);
    check(int'(r) == exp_unit(0, 8), "R12 pop returns oldest", int'(r), exp_unit(0, 8));
    wait_done();
    check(edge_cnt == 136, "R11 resume", edge_cnt, 136);
    bus_wr(A_CTRL, 32'h2);
    @(negedge clk);
    bus_rd(A_STAT, r);
    check(r[14] == 1'b1 && r[12:8] == 0, "R13 rx flush", int'(r[12:8]), 0);

    // R12 full tx FIFO drops the 17th push
    for (int k = 0; k < 17; k++) bus_wr(A_DATA, 32'(k));
    bus_rd(A_STAT, r);
    check(int'(r[20:16]) == 16 && r[23] && !r[22], "R12 tx full", int'(r[20:16]), 16);
    bus_wr(A_CTRL, 32'h4);
    @(negedge clk);
    bus_rd(A_CTRL, r); check(r[2:0] == 0, "R13 bits self clear", int'(r), 0);
    bus_rd(A_STAT, r);
    check(r[22] && r[20:16] == 0, "R13 tx flush", int'(r[20:16]), 0);

    // R13 abort mid read
    bus_wr(A_TIME, 3);
    bus_wr(A_XCTL, (32'd2 << 24) | 32'd3);
    bus_wr(A_CMD, 1);
    repeat (20) @(negedge clk);
    bus_wr(A_CTRL, 32'h1);
    @(negedge clk);
    bus_rd(A_STAT, r);
    check(cs_n === 1'b1 && r[0] == 1'b0, "R13 engine abort", {r[0], cs_n}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule